// File: doc/BRIEF.md
# SHA-512 Block Compressor, Five Rounds per Cycle

This block applies the SHA-512 compression function to a single 1024-bit message block. The caller supplies a 512-bit chaining value along with the block and pulses a start strobe. After 16 clock cycles the block returns the updated chaining value and marks it with a one-cycle done pulse. The 80 rounds are grouped five to a clock cycle, so one pass through the round logic covers five rounds.

Padding, length encoding and carrying the chaining value from one block to the next are left to the caller. A message that fits in one padded block gives its digest after one call with the standard initial value. Longer messages feed each result back as the next chaining input.

The message schedule is held in a 16-word sliding window that advances five words per cycle. The 80 round constants are derived at elaboration from the first 80 primes. The final feed-forward addition is done inside the block.

Top module: `sha512_unrolled_core`

## Requirements
- R1: When start is high and the block is idle, the rising edge captures msgBlock and chainIn. Changes to those inputs after that edge have no effect on the result.
- R2: done is high for exactly one cycle. It rises on the 16th rising edge after the edge that accepted start, and it stays low on the 15 edges in between.
- R3: While a block is in progress, start is ignored. The running computation and its done timing are unchanged, and no second computation is launched.
- R4: chainOut equals the SHA-512 compression of the captured block and chaining value. This covers 80 rounds using the cube-root prime constants, followed by per-word addition modulo 2^64 of the input chaining words. With the standard initial value, the padded "abc" block and the padded empty block give their standard digests.
- R5: Word order is big-endian, with the first word in the most significant bits. Schedule word W0 is msgBlock[1023:960] and W15 is msgBlock[63:0]. Chaining word a is chainIn[511:448] and h is chainIn[63:0]. chainOut uses the same order as chainIn.
- R6: chainOut keeps its value from one completion until the next completion.
- R7: While reset is low, done is 0 and chainOut is all zeros, and the block is idle afterwards.
- R8: A start presented in the cycle in which done is high is accepted. The second result follows 16 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, accepted only when idle |
| msgBlock | input | 1024 | Padded message block, W0 in the top bits |
| chainIn | input | 512 | Chaining value, word a in the top bits |
| chainOut | output | 512 | Updated chaining value, held until the next completion |
| done | output | 1 | One-cycle pulse marking a new chainOut |

## Verification
The assertions assume that start is a clean synchronous strobe. They also assume reset is held for at least one edge before the first start, so the control counter and busy flag begin from a known idle state. The stimulus drives start, msgBlock and chainIn only on falling edges, well clear of the sampling edge. It deliberately pulses start during a busy run and scrambles the data inputs after acceptance, so the ignore and capture rules are exercised rather than merely assumed.

// File: rtl/sha512_pkg.sv
package sha512_pkg;

  localparam int WORD   = 64;
  localparam int ROUNDS = 80;
  localparam int UNROLL = 5;
  localparam int ITERS  = ROUNDS / UNROLL;
  localparam int ITW    = $clog2(ITERS);
  localparam int KIW    = $clog2(ROUNDS);
  localparam int WIN    = 16;

  typedef logic [WORD-1:0] wordT;
  typedef logic [7:0][WORD-1:0] workT;   // index 0 = a ... 7 = h

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } ctrlT;

  function automatic wordT rotr(wordT x, int n);
    return (x >> n) | (x << (WORD - n));
  endfunction

  function automatic wordT smallSig0(wordT x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic wordT smallSig1(wordT x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction

  function automatic wordT bigSig0(wordT x);
    return rotr(x, 28) ^ rotr(x, 34) ^ rotr(x, 39);
  endfunction

  function automatic wordT bigSig1(wordT x);
    return rotr(x, 14) ^ rotr(x, 18) ^ rotr(x, 41);
  endfunction

  function automatic workT roundFn(workT s, wordT k, wordT w);
    wordT t1, t2;
    workT r;
    t1 = s[7] + bigSig1(s[4]) + ((s[4] & s[5]) ^ (~s[4] & s[6])) + k + w;
    t2 = bigSig0(s[0]) + ((s[0] & s[1]) ^ (s[0] & s[2]) ^ (s[1] & s[2]));
    r[0] = t1 + t2;
    r[1] = s[0];
    r[2] = s[1];
    r[3] = s[2];
    r[4] = s[3] + t1;
    r[5] = s[4];
    r[6] = s[5];
    r[7] = s[6];
    return r;
  endfunction

  // Fractional part of the cube root of the idx-th prime, 64 bits.
  function automatic wordT roundConst(int idx);
    int cnt;
    int pr;
    bit isP;
    logic [209:0] tgt;
    logic [209:0] cand;
    logic [209:0] r;
    cnt = 0;
    pr  = 2;
    for (int n = 2; n < 420; n++) begin
      isP = 1'b1;
      for (int d = 2; d < 21; d++) begin
        if (d < n && (n % d) == 0) isP = 1'b0;
      end
      if (isP) begin
        if (cnt == idx) pr = n;
        cnt++;
      end
    end
    tgt = 210'(pr) << 192;
    r   = '0;
    for (int b = 66; b >= 0; b--) begin
      cand = r | (210'(1) << b);
      if (cand * cand * cand <= tgt) r = cand;
    end
    return r[WORD-1:0];
  endfunction

endpackage

// File: rtl/sha512_krom.sv
module sha512_krom
  import sha512_pkg::*;
(
  input  logic [ITW-1:0]         iter,
  output logic [UNROLL-1:0][WORD-1:0] kOut
);

  wordT kTab [ROUNDS];

  for (genvar k = 0; k < ROUNDS; k++) begin : g_tab
    assign kTab[k] = roundConst(k);
  end

  for (genvar j = 0; j < UNROLL; j++) begin : g_sel
    logic [KIW-1:0] kSel;
    assign kSel    = KIW'(iter) * KIW'(UNROLL) + KIW'(j);
    assign kOut[j] = kTab[kSel];
  end

endmodule

// File: rtl/sha512_ctrl.sv
module sha512_ctrl
  import sha512_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  output ctrlT           ctrl,
  output logic [ITW-1:0] iter,
  output logic           done
);

  logic busy;

  assign ctrl.load   = start && !busy;
  assign ctrl.step   = busy;
  assign ctrl.finish = busy && (iter == ITW'(ITERS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      iter <= '0;
      done <= 1'b0;
    end else begin
      done <= ctrl.finish;
      if (ctrl.load) begin
        busy <= 1'b1;
        iter <= '0;
      end else if (ctrl.finish) begin
        busy <= 1'b0;
        iter <= '0;
      end else if (busy) begin
        iter <= iter + 1'b1;
      end
    end
  end

  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: done appears only once the run has ended
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R1: an idle start launches a run from the first iteration
  a_r1_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && iter == '0));

  // R3: start during a run does not disturb the iteration count
  a_r3_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && iter != ITW'(ITERS - 1)) |=> (busy && iter == $past(iter) + 1'b1));

endmodule

// File: rtl/sha512_datapath.sv
module sha512_datapath
  import sha512_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlT                        ctrl,
  input  logic [UNROLL-1:0][WORD-1:0] kIn,
  input  logic [WIN*WORD-1:0]         msgBlock,
  input  logic [8*WORD-1:0]           chainIn,
  output logic [8*WORD-1:0]           chainOut
);

  workT  stReg;
  workT  hReg;
  wordT  wReg [WIN];
  workT  stage [UNROLL+1];
  wordT  ext [WIN+UNROLL];
  workT  chainWords;

  for (genvar i = 0; i < 8; i++) begin : g_cw
    assign chainWords[i] = chainIn[(8-i)*WORD-1 -: WORD];
  end

  // Message schedule: window plus UNROLL freshly expanded words
  for (genvar i = 0; i < WIN; i++) begin : g_win
    assign ext[i] = wReg[i];
  end
  for (genvar j = 0; j < UNROLL; j++) begin : g_exp
    assign ext[WIN+j] = smallSig1(ext[WIN-2+j]) + ext[WIN-7+j]
                      + smallSig0(ext[j+1]) + ext[j];
  end

  // Unrolled rounds
  assign stage[0] = stReg;
  for (genvar j = 0; j < UNROLL; j++) begin : g_rnd
    assign stage[j+1] = roundFn(stage[j], kIn[j], wReg[j]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stReg    <= '0;
      hReg     <= '0;
      chainOut <= '0;
      for (int i = 0; i < WIN; i++) wReg[i] <= '0;
    end else begin
      if (ctrl.load) begin
        stReg <= chainWords;
        hReg  <= chainWords;
        for (int i = 0; i < WIN; i++) wReg[i] <= msgBlock[(WIN-i)*WORD-1 -: WORD];
      end else if (ctrl.step) begin
        stReg <= stage[UNROLL];
        for (int i = 0; i < WIN; i++) wReg[i] <= ext[i+UNROLL];
      end
      if (ctrl.finish) begin
        for (int i = 0; i < 8; i++)
          chainOut[(8-i)*WORD-1 -: WORD] <= stage[UNROLL][i] + hReg[i];
      end
    end
  end

  // R6: the result only moves on completion
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.finish |=> $stable(chainOut));

  // R1: the captured chaining value stays put for the whole run
  a_r1_chain_held: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(hReg));

endmodule

// File: rtl/sha512_unrolled_core.sv
module sha512_unrolled_core
  import sha512_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [1023:0] msgBlock,
  input  logic [511:0]  chainIn,
  output logic [511:0]  chainOut,
  output logic          done
);

  ctrlT                        ctrl;
  logic [ITW-1:0]              iter;
  logic [UNROLL-1:0][WORD-1:0] kVals;

  sha512_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .iter  (iter),
    .done  (done)
  );

  sha512_krom u_krom (
    .iter (iter),
    .kOut (kVals)
  );

  sha512_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .kIn      (kVals),
    .msgBlock (msgBlock),
    .chainIn  (chainIn),
    .chainOut (chainOut)
  );

endmodule

// File: tb/sim_sha512_unrolled_core.sv
module sim_sha512_unrolled_core;

  logic          clk = 1'b0;
  logic          rstN;
  logic          start;
  logic [1023:0] msgBlock;
  logic [511:0]  chainIn;
  logic [511:0]  chainOut;
  logic          done;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;   // 250 MHz

  sha512_unrolled_core u0 (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .msgBlock (msgBlock),
    .chainIn  (chainIn),
    .chainOut (chainOut),
    .done     (done)
  );

  localparam logic [511:0] IV = {
    64'h6a09e667f3bcc908, 64'hbb67ae8584caa73b, 64'h3c6ef372fe94f82b, 64'ha54ff53a5f1d36f1,
    64'h510e527fade682d1, 64'h9b05688c2b3e6c1f, 64'h1f83d9abfb41bd6b, 64'h5be0cd19137e2179};
  localparam logic [1023:0] ABC_BLK   = {64'h6162638000000000, {14{64'h0}}, 64'h18};
  localparam logic [1023:0] EMPTY_BLK = {64'h8000000000000000, {15{64'h0}}};
  localparam logic [511:0] ABC_DIG = {
    64'hddaf35a193617aba, 64'hcc417349ae204131, 64'h12e6fa4e89a97ea2, 64'h0a9eeee64b55d39a,
    64'h2192992a274fc1a8, 64'h36ba3c23a3feebbd, 64'h454d4423643ce80e, 64'h2a9ac94fa54ca49f};
  localparam logic [511:0] EMPTY_DIG = {
    64'hcf83e1357eefb8bd, 64'hf1542850d66d8007, 64'hd620e4050b5715dc, 64'h83f4a921d36ce9ce,
    64'h47d0d13c5d85f2b0, 64'hff8318d2877eec2f, 64'h63b931bd47417a81, 64'ha538327af927da3e};

  typedef struct packed {
    logic [1023:0] msg;
    logic [511:0]  chain;
    logic [511:0]  digest;
  } vecT;

  localparam vecT VECS [2] = '{
    '{msg: ABC_BLK,   chain: IV, digest: ABC_DIG},
    '{msg: EMPTY_BLK, chain: IV, digest: EMPTY_DIG}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doStart(input logic [1023:0] m, input logic [511:0] c);
    start    = 1'b1;
    msgBlock = m;
    chainIn  = c;
  endtask

  // Called at a falling edge with start already raised.
  task automatic waitResult(input string req, input logic [511:0] exp,
                            input int injectAt, input bit scramble);
    bit early = 1'b0;
    @(posedge clk);          // accepting edge
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      msgBlock = '1;
      chainIn  = '0;
    end
    for (int i = 0; i < 15; i++) begin
      if (i == injectAt) begin
        start    = 1'b1;
        msgBlock = EMPTY_BLK;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      if (done) early = 1'b1;
    end
    check(!early, "R2", "done before 16th edge", 512'(early), 512'(0));
    @(posedge clk);
    @(negedge clk);
    check(done, "R2", "done on 16th edge", 512'(done), 512'(1));
    check(chainOut == exp, req, "digest", chainOut, exp);
  endtask

  task automatic afterPulse(input logic [511:0] prev);
    @(posedge clk);
    @(negedge clk);
    check(!done, "R2", "done single cycle", 512'(done), 512'(0));
    check(chainOut == prev, "R6", "result held", chainOut, prev);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    checks++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN     = 1'b0;
    start    = 1'b0;
    msgBlock = '0;
    chainIn  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state
    check(done == 1'b0, "R7", "done in reset", 512'(done), 512'(0));
    check(chainOut == '0, "R7", "chainOut in reset", chainOut, '0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 R5: known-answer vectors
    for (int v = 0; v < 2; v++) begin
      doStart(VECS[v].msg, VECS[v].chain);
      waitResult("R4", VECS[v].digest, -1, 1'b0);
      afterPulse(VECS[v].digest);
    end

    // R1: inputs scrambled right after acceptance
    doStart(ABC_BLK, IV);
    waitResult("R1", ABC_DIG, -1, 1'b1);
    afterPulse(ABC_DIG);

    // R3: start pulsed mid-run with another block
    doStart(ABC_BLK, IV);
    waitResult("R3", ABC_DIG, 4, 1'b0);
    afterPulse(ABC_DIG);
    begin
      bit extra = 1'b0;
      for (int i = 0; i < 10; i++) begin
        @(posedge clk);
        @(negedge clk);
        if (done) extra = 1'b1;
      end
      check(!extra, "R3", "no second run launched", 512'(extra), 512'(0));
    end

    // R8: back-to-back, second start while done is high
    doStart(ABC_BLK, IV);
    waitResult("R4", ABC_DIG, -1, 1'b0);
    doStart(EMPTY_BLK, IV);
    waitResult("R8", EMPTY_DIG, -1, 1'b0);
    afterPulse(EMPTY_DIG);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule